// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Monitor

This block sits beside an SDRAM command bus and samples the control pins on every rising clock edge. It turns the chip-select, row-strobe, column-strobe and write-enable levels into a named command. It also keeps a model of the four banks: for each bank, whether it is open and which row it holds. It holds a shadow copy of the mode register fields, and it tracks auto-precharge so that a bank closes by itself once its burst has run out.

Protocol breaches are caught and latched into one sticky error code. The code keeps the first breach and the bank address seen with it, until a clear pulse arrives. The byte-mask lanes come out along two paths. A write mask is aligned with the decoded command. A read-side high-impedance indication follows the mask sampled two edges earlier. Every output is registered and changes just after the edge that sampled the command.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After each edge, `cmd_o` holds the code of the command sampled at that edge. The codes are: chip-select high 0 (inhibit), NOP 1, ACTIVE 2, READ 3, WRITE 4, burst stop 5, PRECHARGE 6, auto refresh 7, self refresh 8, mode load 9. The pin pattern {RAS,CAS,WE} = LLH gives 7 when `cke_i` is high and 8 when it is low.
- R2: ACTIVE to an idle bank opens that bank and stores `addr_i` as its row. ACTIVE to an open bank leaves the bank unchanged and raises error code 1.
- R3: READ or WRITE to an idle bank changes no bank state and raises error code 2.
- R4: PRECHARGE with `addr_i[10]` high closes every bank, whatever `ba_i` holds. With `addr_i[10]` low it closes only bank `ba_i`.
- R5: READ or WRITE to an open bank with `addr_i[10]` high closes that bank B edges later. If the command is sampled at edge n, the bank reads idle after edge n+B. B is 1, 2, 4 or 8 for burst-length codes 0 to 3, and 1 for any other code. B is also 1 for a WRITE when write-single mode (mode bit 9) is set.
- R6: When the burst-length code is 7 and the burst type is 0 (full page), `addr_i[10]` on READ or WRITE has no effect and the bank stays open.
- R7: A mode load while every bank is idle captures the fields from `addr_i`: length in bits 2:0, type in bit 3, latency in bits 6:4, operating mode in bits 8:7, write-single in bit 9. A mode load while any bank is open leaves the fields unchanged and raises error code 3.
- R8: Any command other than NOP or inhibit in the two edges after a mode load raises error code 4.
- R9: `rd_hiz_o` after edge n+2 equals `dqm_i` as sampled at edge n.
- R10: `wr_mask_o` after edge n equals `dqm_i` as sampled at edge n.
- R11: The error code and its bank (`ba_i` of the offending command) hold the first breach until `err_clr_i` is sampled high. A breach in the same cycle as a clear is captured. Codes 1 to 3 win over code 4 when both occur together.
- R12: While reset is asserted, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Address bus |
| dqm_i | input | 2 | Byte mask lanes |
| err_clr_i | input | 1 | Clears the sticky error |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | 4 | Open flag per bank |
| bank_row_o | output | 48 | Open row per bank, bank b at bits 12b+11:12b |
| burst_len_o | output | 3 | Captured burst-length code |
| burst_type_o | output | 1 | Captured burst type |
| cas_lat_o | output | 3 | Captured read latency |
| op_mode_o | output | 2 | Captured operating mode |
| wr_single_o | output | 1 | Captured write-single flag |
| rd_hiz_o | output | 2 | Read lanes forced to high impedance |
| wr_mask_o | output | 2 | Write lanes masked |
| err_code_o | output | 3 | Sticky error code |
| err_bank_o | output | 2 | Bank address of the latched error |

## Verification
The bound checker checks these rules on every cycle: the ACTIVE decode, the row stored on ACTIVE, the all-bank precharge, the error raised by an access to an idle bank, the refusal of a mode load while a bank is open, the two mask delays, and the hold of a latched error. The timed close of an auto-precharged bank under each burst length can only be shown by the bench's scenarios. The same holds for the full-page exception, the mode-load gap, the order of errors raised in one cycle, and a clear that meets a new breach. The bench's behavioural model compares every output against its own expectation on every clock, including a long run of random pin patterns.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACTIVE  = 4'd2,
    CMD_READ    = 4'd3,
    CMD_WRITE   = 4'd4,
    CMD_BSTOP   = 4'd5,
    CMD_PRECH   = 4'd6,
    CMD_AREF    = 4'd7,
    CMD_SREF    = 4'd8,
    CMD_LMODE   = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ACT_OPEN = 3'd1,
    ERR_RW_IDLE  = 3'd2,
    ERR_LM_BUSY  = 3'd3,
    ERR_LM_GAP   = 3'd4
  } err_e;

  // Field order matches the bit positions of the mode word on the address bus
  typedef struct packed {
    logic       wr_single;
    logic [1:0] op_mode;
    logic [2:0] cas_lat;
    logic       burst_type;
    logic [2:0] burst_len;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  output cmd_e cmd_o
);

  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_INHIBIT;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACTIVE;
        3'b101:  cmd_o = CMD_READ;
        3'b100:  cmd_o = CMD_WRITE;
        3'b110:  cmd_o = CMD_BSTOP;
        3'b010:  cmd_o = CMD_PRECH;
        3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF;
        default: cmd_o = CMD_LMODE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_mode_shadow.sv
module sdram_mode_shadow
  import sdram_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  output mode_t             mode_o,
  output logic              full_page_o,
  output logic [CNT_W-1:0]  rd_beats_o,
  output logic [CNT_W-1:0]  wr_beats_o
);

  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= '0;
    else if (load_i) mode_q <= mode_t'(word_i);
  end

  // Codes 0..3 give 1,2,4,8 beats; every other code counts as one beat
  always_comb begin
    if (mode_q.burst_len <= 3'd3) rd_beats_o = CNT_W'(1) << mode_q.burst_len;
    else                          rd_beats_o = CNT_W'(1);
    wr_beats_o  = mode_q.wr_single ? CNT_W'(1) : rd_beats_o;
    full_page_o = (mode_q.burst_len == 3'b111) && !mode_q.burst_type;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] beats_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
      left_q <= '0;
    end else if (pre_i) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else if (act_i && !open_q) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (ap_i && open_q) begin
      left_q <= beats_i;
    end else if (left_q == CNT_W'(1)) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;

endmodule

// File: rtl/sdram_mask_delay.sv
module sdram_mask_delay #(
  parameter int W   = 2,
  parameter int LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] dqm_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] late_o
);

  logic [W-1:0] pipe_q [LAT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= LAT; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= dqm_i;
      for (int i = 1; i <= LAT; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign now_o  = pipe_q[0];
  assign late_o = pipe_q[LAT];

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int ADDR_W    = 12,
  parameter int ROW_W     = 12,
  parameter int DQM_W     = 2,
  parameter int DQM_LAT   = 2,
  parameter int T_MRD     = 2,
  parameter int AP_BIT    = 10,
  parameter int MAX_BEATS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic                       cke_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DQM_W-1:0]           dqm_i,
  input  logic                       err_clr_i,
  output logic [3:0]                 cmd_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  output logic [2:0]                 burst_len_o,
  output logic                       burst_type_o,
  output logic [2:0]                 cas_lat_o,
  output logic [1:0]                 op_mode_o,
  output logic                       wr_single_o,
  output logic [DQM_W-1:0]           rd_hiz_o,
  output logic [DQM_W-1:0]           wr_mask_o,
  output logic [2:0]                 err_code_o,
  output logic [BA_W-1:0]            err_bank_o
);

  localparam int CNT_W = $clog2(MAX_BEATS + 1);
  localparam int GAP_W = $clog2(T_MRD + 1);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] open_vec;
  mode_t                mode;
  logic                 full_page;
  logic [CNT_W-1:0]     rd_beats, wr_beats, beats;
  logic                 is_rw, ap_req, lm_ok, sel_open;

  sdram_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cke_i  (cke_i),
    .cmd_o  (cmd)
  );

  assign sel_open = open_vec[ba_i];
  assign is_rw    = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign ap_req   = is_rw && addr_i[AP_BIT] && !full_page;
  assign lm_ok    = (cmd == CMD_LMODE) && (open_vec == '0);
  assign beats    = (cmd == CMD_WRITE) ? wr_beats : rd_beats;

  sdram_mode_shadow #(.CNT_W(CNT_W)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (lm_ok),
    .word_i      (addr_i[MODE_W-1:0]),
    .mode_o      (mode),
    .full_page_o (full_page),
    .rd_beats_o  (rd_beats),
    .wr_beats_o  (wr_beats)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (ba_i == BA_W'(b));
    sdram_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   ((cmd == CMD_ACTIVE) && hit),
      .pre_i   ((cmd == CMD_PRECH) && (addr_i[AP_BIT] || hit)),
      .ap_i    (ap_req && hit),
      .row_i   (addr_i[ROW_W-1:0]),
      .beats_i (beats),
      .open_o  (open_vec[b]),
      .row_o   (bank_row_o[b*ROW_W +: ROW_W])
    );
  end

  // Gap counter after a mode load
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 gap_q <= '0;
    else if (cmd == CMD_LMODE)   gap_q <= GAP_W'(T_MRD);
    else if (gap_q != '0)        gap_q <= gap_q - GAP_W'(1);
  end

  // Bank rule breaches outrank the mode-load gap breach
  err_e viol;
  always_comb begin
    viol = ERR_NONE;
    if ((cmd == CMD_ACTIVE) && sel_open)          viol = ERR_ACT_OPEN;
    else if (is_rw && !sel_open)                  viol = ERR_RW_IDLE;
    else if ((cmd == CMD_LMODE) && !lm_ok)        viol = ERR_LM_BUSY;
    else if ((gap_q != '0) && (cmd != CMD_NOP) && (cmd != CMD_INHIBIT))
                                                  viol = ERR_LM_GAP;
  end

  err_e            err_q;
  logic [BA_W-1:0] err_bank_q;
  cmd_e            cmd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q      <= ERR_NONE;
      err_bank_q <= '0;
      cmd_q      <= CMD_INHIBIT;
    end else begin
      cmd_q <= cmd;
      if (err_clr_i || (err_q == ERR_NONE)) begin
        err_q      <= viol;
        err_bank_q <= (viol != ERR_NONE) ? ba_i : '0;
      end
    end
  end

  sdram_mask_delay #(.W(DQM_W), .LAT(DQM_LAT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dqm_i  (dqm_i),
    .now_o  (wr_mask_o),
    .late_o (rd_hiz_o)
  );

  assign cmd_o        = cmd_q;
  assign bank_open_o  = open_vec;
  assign burst_len_o  = mode.burst_len;
  assign burst_type_o = mode.burst_type;
  assign cas_lat_o    = mode.cas_lat;
  assign op_mode_o    = mode.op_mode;
  assign wr_single_o  = mode.wr_single;
  assign err_code_o   = err_q;
  assign err_bank_o   = err_bank_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 12,
  parameter int ROW_W     = 12,
  parameter int DQM_W     = 2,
  parameter int AP_BIT    = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cs_ni,
  input logic                       ras_ni,
  input logic                       cas_ni,
  input logic                       we_ni,
  input logic [BA_W-1:0]            ba_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DQM_W-1:0]           dqm_i,
  input logic                       err_clr_i,
  input logic [3:0]                 cmd_o,
  input logic [NUM_BANKS-1:0]       bank_open_o,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  input logic [2:0]                 burst_len_o,
  input logic                       burst_type_o,
  input logic [2:0]                 cas_lat_o,
  input logic [1:0]                 op_mode_o,
  input logic                       wr_single_o,
  input logic [DQM_W-1:0]           rd_hiz_o,
  input logic [DQM_W-1:0]           wr_mask_o,
  input logic [2:0]                 err_code_o,
  input logic [BA_W-1:0]            err_bank_o
);

  logic is_act, is_pre, is_rw, is_lm;
  assign is_act = !cs_ni && !ras_ni &&  cas_ni &&  we_ni;
  assign is_pre = !cs_ni && !ras_ni &&  cas_ni && !we_ni;
  assign is_rw  = !cs_ni &&  ras_ni && !cas_ni;
  assign is_lm  = !cs_ni && !ras_ni && !cas_ni && !we_ni;

  logic [1:0]        since_q;
  logic [BA_W-1:0]   ba_q;
  logic [ROW_W-1:0]  row_q;
  logic [DQM_W-1:0]  dqm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      ba_q    <= '0;
      row_q   <= '0;
      dqm_q   <= '0;
    end else begin
      if (since_q != 2'd3) since_q <= since_q + 2'd1;
      ba_q  <= ba_i;
      row_q <= addr_i[ROW_W-1:0];
      dqm_q <= dqm_i;
    end
  end

  a_r1_active_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |=> cmd_o == 4'd2);

  a_r2_active_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act && !bank_open_o[ba_i] |=>
      bank_open_o[ba_q] && (bank_row_o[ba_q*ROW_W +: ROW_W] == row_q));

  a_r3_rw_idle_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rw && !bank_open_o[ba_i] && (err_code_o == 3'd0) |=>
      (err_code_o == 3'd2) && (err_bank_o == ba_q));

  a_r4_close_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre && addr_i[AP_BIT] |=> bank_open_o == '0);

  a_r7_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lm && (bank_open_o != '0) |=>
      $stable({burst_len_o, burst_type_o, cas_lat_o, op_mode_o, wr_single_o}));

  a_r9_rd_hiz_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q == 2'd3 |-> rd_hiz_o == $past(dqm_i, 3));

  a_r10_wr_mask_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q != 2'd0 |-> wr_mask_o == dqm_q);

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != 3'd0) && !err_clr_i |=> $stable(err_code_o) && $stable(err_bank_o));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BA_W      (BA_W),
  .ADDR_W    (ADDR_W),
  .ROW_W     (ROW_W),
  .DQM_W     (DQM_W),
  .AP_BIT    (AP_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .ras_ni       (ras_ni),
  .cas_ni       (cas_ni),
  .we_ni        (we_ni),
  .ba_i         (ba_i),
  .addr_i       (addr_i),
  .dqm_i        (dqm_i),
  .err_clr_i    (err_clr_i),
  .cmd_o        (cmd_o),
  .bank_open_o  (bank_open_o),
  .bank_row_o   (bank_row_o),
  .burst_len_o  (burst_len_o),
  .burst_type_o (burst_type_o),
  .cas_lat_o    (cas_lat_o),
  .op_mode_o    (op_mode_o),
  .wr_single_o  (wr_single_o),
  .rd_hiz_o     (rd_hiz_o),
  .wr_mask_o    (wr_mask_o),
  .err_code_o   (err_code_o),
  .err_bank_o   (err_bank_o)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, cke_i = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [11:0] addr_i = '0;
  logic [1:0]  dqm_i = '0;
  logic        err_clr_i = 1'b0;

  logic [3:0]  cmd_o;
  logic [3:0]  bank_open_o;
  logic [47:0] bank_row_o;
  logic [2:0]  burst_len_o, cas_lat_o, err_code_o;
  logic        burst_type_o, wr_single_o;
  logic [1:0]  op_mode_o, rd_hiz_o, wr_mask_o, err_bank_o;

  always #2.5 clk_i = ~clk_i;

  sdram_cmd_monitor dut_i (
    .clk_i, .rst_ni, .cs_ni, .ras_ni, .cas_ni, .we_ni, .cke_i, .ba_i, .addr_i,
    .dqm_i, .err_clr_i, .cmd_o, .bank_open_o, .bank_row_o, .burst_len_o,
    .burst_type_o, .cas_lat_o, .op_mode_o, .wr_single_o, .rd_hiz_o, .wr_mask_o,
    .err_code_o, .err_bank_o
  );

  int n_chk = 0, n_bad = 0;
  bit running = 0, done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_open[4], m_row[4], m_left[4];
  int m_len, m_type, m_cl, m_op, m_ws;
  int m_gap, m_err, m_ebank, m_cmd, m_wrm, m_rd;
  int dq[$];

  function automatic int code_of(bit cs, bit r, bit c, bit w, bit k);
    if (cs) return 0;
    case ({r, c, w})
      3'b111: return 1;
      3'b011: return 2;
      3'b101: return 3;
      3'b100: return 4;
      3'b110: return 5;
      3'b010: return 6;
      3'b001: return k ? 7 : 8;
      default: return 9;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; m_left[b] = 0; end
      m_len = 0; m_type = 0; m_cl = 0; m_op = 0; m_ws = 0;
      m_gap = 0; m_err = 0; m_ebank = 0; m_cmd = 0; m_wrm = 0; m_rd = 0;
      dq.delete();
    end else begin
      int c, ba, viol, any_open, nb;
      bit fp;
      c = code_of(cs_ni, ras_ni, cas_ni, we_ni, cke_i);
      ba = ba_i;
      any_open = 0;
      for (int b = 0; b < 4; b++) if (m_open[b] != 0) any_open = 1;
      viol = 0;
      if (c == 2 && m_open[ba] != 0) viol = 1;
      else if ((c == 3 || c == 4) && m_open[ba] == 0) viol = 2;
      else if (c == 9 && any_open != 0) viol = 3;
      else if (m_gap > 0 && c > 1) viol = 4;
      fp = (m_len == 7 && m_type == 0);
      if (c == 4 && m_ws != 0) nb = 1;
      else if (m_len <= 3) nb = 1 << m_len;
      else nb = 1;
      for (int b = 0; b < 4; b++) begin
        if (c == 6 && (addr_i[10] || ba == b)) begin m_open[b] = 0; m_left[b] = 0; end
        else if (c == 2 && ba == b && m_open[b] == 0) begin m_open[b] = 1; m_row[b] = addr_i; end
        else if ((c == 3 || c == 4) && ba == b && addr_i[10] && !fp && m_open[b] != 0) m_left[b] = nb;
        else if (m_left[b] == 1) begin m_open[b] = 0; m_left[b] = 0; end
        else if (m_left[b] > 0) m_left[b]--;
      end
      if (c == 9 && any_open == 0) begin
        m_len = addr_i[2:0]; m_type = addr_i[3]; m_cl = addr_i[6:4];
        m_op = addr_i[8:7]; m_ws = addr_i[9];
      end
      if (c == 9) m_gap = 2; else if (m_gap > 0) m_gap--;
      if (err_clr_i || m_err == 0) begin m_err = viol; m_ebank = (viol != 0) ? ba : 0; end
      m_cmd = c;
      m_wrm = dqm_i;
      dq.push_back(int'(dqm_i));
      if (dq.size() > 3) void'(dq.pop_front());
      m_rd = (dq.size() == 3) ? dq[0] : 0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && running) begin
      int open_v;
      open_v = 0;
      for (int b = 0; b < 4; b++) if (m_open[b] != 0) open_v |= (1 << b);
      check(cmd_o == m_cmd, "R1 cmd", cmd_o, m_cmd);
      check(wr_mask_o == m_wrm, "R10 wr_mask", wr_mask_o, m_wrm);
      check(rd_hiz_o == m_rd, "R9 rd_hiz", rd_hiz_o, m_rd);
      check(bank_open_o == open_v, "R2 R4 R5 R6 bank_open", bank_open_o, open_v);
      for (int b = 0; b < 4; b++)
        check(int'(bank_row_o[b*12 +: 12]) == m_row[b], "R2 row", bank_row_o[b*12 +: 12], m_row[b]);
      check({burst_len_o, burst_type_o, cas_lat_o, op_mode_o, wr_single_o} ==
            {m_len[2:0], m_type[0], m_cl[2:0], m_op[1:0], m_ws[0]}, "R7 mode",
            {wr_single_o, op_mode_o, cas_lat_o, burst_type_o, burst_len_o},
            {m_ws[0], m_op[1:0], m_cl[2:0], m_type[0], m_len[2:0]});
      check(err_code_o == m_err, "R11 err_code", err_code_o, m_err);
      check(err_bank_o == m_ebank, "R11 err_bank", err_bank_o, m_ebank);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit cs, input bit r, input bit c, input bit w,
                     input int ba, input int a, input int m);
    cs_ni = cs; ras_ni = r; cas_ni = c; we_ni = w;
    ba_i = ba[1:0]; addr_i = a[11:0]; dqm_i = m[1:0];
    @(negedge clk_i);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, 0, 0, 0);
  endtask
  task automatic act(input int b, input int row); cyc(0, 0, 1, 1, b, row, 0); endtask
  task automatic rd(input int b, input int a, input int m); cyc(0, 1, 0, 1, b, a, m); endtask
  task automatic wr(input int b, input int a, input int m); cyc(0, 1, 0, 0, b, a, m); endtask
  task automatic pre(input int b, input bit all); cyc(0, 0, 1, 0, b, all ? 12'h400 : 0, 0); endtask
  task automatic lmode(input int a); cyc(0, 0, 0, 0, 0, a, 0); endtask
  task automatic clear_nop(); err_clr_i = 1; nop(1); err_clr_i = 0; endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(cmd_o == 0 && bank_open_o == 0 && err_code_o == 0 && rd_hiz_o == 0 &&
          wr_mask_o == 0 && burst_len_o == 0 && cas_lat_o == 0, "R12 reset state",
          {bank_open_o, cmd_o}, 0);
    rst_ni = 1;
    running = 1;
    cyc(1, 0, 0, 0, 0, 0, 0);
    nop(1);
    lmode(12'h032);                      // len 4 beats, latency 3
    check(burst_len_o == 2 && cas_lat_o == 3, "R7 mode load", burst_len_o, 2);
    nop(2);
    act(0, 12'hABC);
    act(2, 12'h123);
    rd(0, 5, 2'b10);
    wr(2, 7, 2'b01);
    check(wr_mask_o == 2'b01, "R10 write mask", wr_mask_o, 1);
    nop(1);
    check(rd_hiz_o == 2'b10, "R9 read mask delay", rd_hiz_o, 2);
    nop(2);
    pre(0, 0);
    check(bank_open_o == 4'b0100, "R4 single close", bank_open_o, 4);
    pre(3, 1);
    check(bank_open_o == 0, "R4 close all", bank_open_o, 0);
    act(1, 12'h055);
    rd(1, 12'h403, 0);                   // auto precharge, 4 beats
    nop(3);
    check(bank_open_o[1] == 1, "R5 still open", bank_open_o[1], 1);
    nop(1);
    check(bank_open_o[1] == 0, "R5 closed after burst", bank_open_o[1], 0);
    rd(3, 0, 0);
    check(err_code_o == 2 && err_bank_o == 3, "R3 read idle bank", err_code_o, 2);
    act(1, 1); act(1, 2);
    check(err_code_o == 2, "R11 first error held", err_code_o, 2);
    clear_nop();
    check(err_code_o == 0, "R11 cleared", err_code_o, 0);
    act(1, 3);
    check(err_code_o == 1 && err_bank_o == 1, "R2 active on open", err_code_o, 1);
    clear_nop();
    lmode(12'h020);
    check(err_code_o == 3 && burst_len_o == 2, "R7 load while open", err_code_o, 3);
    clear_nop();
    nop(1);
    pre(0, 1);
    nop(1);
    lmode(12'h007);                      // full page, sequential
    act(0, 12'h111);
    check(err_code_o == 4 && err_bank_o == 0, "R8 load gap", err_code_o, 4);
    clear_nop();
    rd(0, 12'h400, 0);
    nop(10);
    check(bank_open_o[0] == 1, "R6 full page keeps bank", bank_open_o[0], 1);
    pre(0, 1);
    lmode(12'h201);                      // 2 beats, write single
    nop(2);
    act(3, 12'hFED);
    wr(3, 12'h400, 0);
    nop(1);
    check(bank_open_o[3] == 0, "R5 write single closes", bank_open_o[3], 0);
    cke_i = 0; cyc(0, 0, 0, 1, 0, 0, 0); cke_i = 1;
    check(cmd_o == 8, "R1 self refresh", cmd_o, 8);
    cyc(0, 0, 0, 1, 0, 0, 0);
    check(cmd_o == 7, "R1 auto refresh", cmd_o, 7);
    cyc(0, 1, 1, 0, 0, 0, 0);
    check(cmd_o == 5, "R1 burst stop", cmd_o, 5);
    rd(2, 0, 0);
    err_clr_i = 1; rd(1, 0, 0); err_clr_i = 0;
    check(err_code_o == 2 && err_bank_o == 1, "R11 clear with new breach", err_bank_o, 1);
    clear_nop();
    for (int i = 0; i < 600; i++) begin
      err_clr_i = ($urandom % 12) == 0;
      cke_i = ($urandom % 8) != 0;
      cyc(($urandom % 8) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
          $urandom % 4, $urandom % 4096, $urandom % 4);
    end
    err_clr_i = 0; cke_i = 1;
    nop(4);
    running = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule